// File: doc/BRIEF.md
# Dual-Protocol Host Register Port

This block is the register port between a host processor and a bank of 8-bit control registers. Two static mode inputs select the host bus style. The protocol input chooses between separate active-low read and write strobes, or one active-low data strobe with a read/write direction line. The bus-sharing input chooses whether address and data share one set of pins or use separate pins. Each register is exported as a flat vector. Two fields of the control register are also exported as named outputs.

The host inputs are asynchronous. Each strobe and the address latch pass through a two-flop synchronizer into the system clock domain. A cycle controller with four states handles the rest:
- `S_IDLE` goes to `S_WRITE` when a write is seen, or to `S_READ` when a read is seen. A write wins if both are present.
- `S_READ` returns to `S_IDLE` when the read condition goes away.
- `S_WRITE` goes to `S_COMMIT` when the write or data strobe is released. The register is written on that transition.
- `S_COMMIT` always returns to `S_IDLE` after one clock.

The cycle address and the write data are both captured on the clock edge that enters `S_READ` or `S_WRITE`. During `S_READ` the block drives read data and raises an output enable for an external tristate buffer. In all other states the bus is released.

Top module: `hostbus_regif`

## Requirements
- R1: After reset all registers read as 0x00, the output enable is low and both exported control fields are 0.
- R2: With `mode_ale`=1, holding `wr_ds_n` low writes the value on `ad_in` into the addressed register. The write takes effect once, on the third rising edge after `wr_ds_n` returns high.
- R3: With `mode_ale`=1, holding `rd_rw` low (read strobe) starts a read cycle. The addressed register appears on `ad_out` while `ad_oe` is high.
- R4: With `mode_ale`=0, `wr_ds_n` is the data strobe and `rd_rw` gives the direction: 1 means read and 0 means write. Data-strobe low with direction 0 writes; data-strobe low with direction 1 reads.
- R5: With `mode_mux`=1, the register address is `ad_in[ADDR_W-1:0]`, sampled on the falling edge of the synchronized `addr_latch`. The address is held until the next falling edge.
- R6: With `mode_mux`=0, the register address is taken from `addr_in` on the edge that starts the cycle.
- R7: `ad_oe` is high only during a read cycle. It rises on the third rising edge after a read strobe asserts and falls on the third edge after it deasserts.
- R8: Each write cycle commits exactly once. The value stored is the `ad_in` value present at the start of the cycle, even if the bus changes later in the cycle.
- R9: Addresses at or above `NUM_REGS` (8 by default) read as 0x00, and writes to them change no register.
- R10: `ctl_dual` equals bit 4 of register 5, and `ctl_cdr` equals bit 0 of register 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_ale | input | 1 | 1: separate read and write strobes; 0: data strobe plus direction line |
| mode_mux | input | 1 | 1: address and data share `ad_in`; 0: separate address pins |
| addr_latch | input | 1 | Address latch or strobe; falling edge captures the address in shared mode |
| wr_ds_n | input | 1 | Write strobe (mode_ale=1) or data strobe (mode_ale=0), active low |
| rd_rw | input | 1 | Read strobe, active low (mode_ale=1), or direction line, 1 = read (mode_ale=0) |
| addr_in | input | ADDR_W | Address pins used when mode_mux=0 |
| ad_in | input | DATA_W | Data bus input; also carries the address when mode_mux=1 |
| ad_out | output | DATA_W | Read data toward the tristate buffer |
| ad_oe | output | 1 | Tristate enable for `ad_out` |
| cfg_regs | output | NUM_REGS*DATA_W | All registers; register i occupies bits [i*DATA_W +: DATA_W] |
| ctl_dual | output | 1 | Dual-rail or single-rail select |
| ctl_cdr | output | 1 | Clock-recovery or data-slicing select |

## Verification
A wrong controller state shows up at the ports within one clock. A read state that is held too long or entered by mistake raises `ad_oe` on a cycle where the bench model expects the bus to be released. A write state that commits twice, or commits with data captured late, leaves a wrong byte in `cfg_regs` on the clock right after the commit edge. A stale or mis-latched shared-bus address writes to the wrong slot, and the per-clock comparison of the whole register vector finds it at once. A dropped or misplaced control bit is seen on `ctl_dual` or `ctl_cdr` on the same clock.

// File: rtl/hbi_pkg.sv
package hbi_pkg;
    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_READ   = 2'd1,
        S_WRITE  = 2'd2,
        S_COMMIT = 2'd3
    } cyc_state_e;
endpackage

// File: rtl/hbi_sync.sv
module hbi_sync #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic stage1, stage2;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage1 <= RST_VAL[b];
                stage2 <= RST_VAL[b];
            end else begin
                stage1 <= d_async[b];
                stage2 <= stage1;
            end
        end
        assign q_sync[b] = stage2;
    end
endmodule

// File: rtl/hbi_cycle_fsm.sv
module hbi_cycle_fsm
    import hbi_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_ale,
    input  logic              mode_mux,
    input  logic              latch_s,
    input  logic              wds_s,
    input  logic              rdrw_s,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] ad_in,
    output logic              wr_en,
    output logic              rd_oe,
    output logic [ADDR_W-1:0] cyc_addr,
    output logic [DATA_W-1:0] cyc_data
);
    cyc_state_e state, state_nx;
    logic              latch_d;
    logic [ADDR_W-1:0] mux_addr;
    logic              rd_act, wr_act, start_cyc;

    always_comb begin
        if (mode_ale) begin
            rd_act = !rdrw_s;
            wr_act = !wds_s;
        end else begin
            rd_act = !wds_s && rdrw_s;
            wr_act = !wds_s && !rdrw_s;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:   if (wr_act) state_nx = S_WRITE;
                      else if (rd_act) state_nx = S_READ;
            S_READ:   if (!rd_act) state_nx = S_IDLE;
            S_WRITE:  if (wds_s) state_nx = S_COMMIT;
            S_COMMIT: state_nx = S_IDLE;
        endcase
    end

    assign start_cyc = (state == S_IDLE) && (wr_act || rd_act);

    // address latch and cycle capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_d  <= 1'b0;
            mux_addr <= '0;
            cyc_addr <= '0;
            cyc_data <= '0;
        end else begin
            latch_d <= latch_s;
            if (start_cyc) begin
                cyc_addr <= mode_mux ? mux_addr : addr_in;
                cyc_data <= ad_in;
            end
            if (latch_d && !latch_s) mux_addr <= ad_in[ADDR_W-1:0];
        end
    end

    // outputs
    always_comb begin
        wr_en = 1'b0;
        rd_oe = 1'b0;
        unique case (state)
            S_READ:  rd_oe = 1'b1;
            S_WRITE: wr_en = wds_s;
            default: ;
        endcase
    end

    // R7
    read_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_READ) |-> $past(rd_act));
    // R8
    single_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);
    // R8
    commit_then_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (state == S_COMMIT));
    // R7
    oe_excludes_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_oe && wr_en));
endmodule

// File: rtl/hbi_regbank.sv
module hbi_regbank #(
    parameter int NUM_REGS = 8,
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic [ADDR_W-1:0]          rd_addr,
    output logic [DATA_W-1:0]          rd_data,
    output logic [NUM_REGS*DATA_W-1:0] regs_flat
);
    logic [DATA_W-1:0] regs [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                  regs[i] <= '0;
            else if (wr_en && wr_addr == ADDR_W'(i))     regs[i] <= wr_data;
        end
        assign regs_flat[i*DATA_W +: DATA_W] = regs[i];
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++)
            if (rd_addr == ADDR_W'(i)) rd_data = regs[i];
    end

    // R9
    unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ({1'b0, wr_addr} >= (ADDR_W+1)'(NUM_REGS))) |=> $stable(regs_flat));
endmodule

// File: rtl/hostbus_regif.sv
module hostbus_regif #(
    parameter int NUM_REGS = 8,
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 8,
    parameter int CTL_REG  = 5,
    parameter int DUAL_BIT = 4,
    parameter int CDR_BIT  = 0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       mode_ale,
    input  logic                       mode_mux,
    input  logic                       addr_latch,
    input  logic                       wr_ds_n,
    input  logic                       rd_rw,
    input  logic [ADDR_W-1:0]          addr_in,
    input  logic [DATA_W-1:0]          ad_in,
    output logic [DATA_W-1:0]          ad_out,
    output logic                       ad_oe,
    output logic [NUM_REGS*DATA_W-1:0] cfg_regs,
    output logic                       ctl_dual,
    output logic                       ctl_cdr
);
    localparam int CTL_BASE = CTL_REG * DATA_W;

    logic [2:0]        sync_q;
    logic              wr_en, rd_oe;
    logic [ADDR_W-1:0] cyc_addr;
    logic [DATA_W-1:0] cyc_data;

    hbi_sync #(.W(3), .RST_VAL(3'b011)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d_async({addr_latch, wr_ds_n, rd_rw}),
        .q_sync(sync_q)
    );

    hbi_cycle_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .mode_ale(mode_ale), .mode_mux(mode_mux),
        .latch_s(sync_q[2]), .wds_s(sync_q[1]), .rdrw_s(sync_q[0]),
        .addr_in(addr_in), .ad_in(ad_in),
        .wr_en(wr_en), .rd_oe(rd_oe),
        .cyc_addr(cyc_addr), .cyc_data(cyc_data)
    );

    hbi_regbank #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(cyc_addr), .wr_data(cyc_data),
        .rd_addr(cyc_addr), .rd_data(ad_out),
        .regs_flat(cfg_regs)
    );

    assign ad_oe    = rd_oe;
    assign ctl_dual = cfg_regs[CTL_BASE + DUAL_BIT];
    assign ctl_cdr  = cfg_regs[CTL_BASE + CDR_BIT];

    // R10
    ctl_changes_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({ctl_dual, ctl_cdr}) |-> $past(wr_en));
endmodule

// File: tb/hostbus_regif_bench.sv
module hostbus_regif_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        mode_ale = 1'b1, mode_mux = 1'b0;
    logic        addr_latch = 1'b0, wr_ds_n = 1'b1, rd_rw = 1'b1;
    logic [3:0]  addr_in = '0;
    logic [7:0]  ad_in = '0;
    logic [7:0]  ad_out;
    logic        ad_oe;
    logic [63:0] cfg_regs;
    logic        ctl_dual, ctl_cdr;

    int checks = 0, fails = 0, cyc = 0;

    hostbus_regif u_hostbus_regif (
        .clk(clk), .rst_n(rst_n), .mode_ale(mode_ale), .mode_mux(mode_mux),
        .addr_latch(addr_latch), .wr_ds_n(wr_ds_n), .rd_rw(rd_rw),
        .addr_in(addr_in), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
        .cfg_regs(cfg_regs), .ctl_dual(ctl_dual), .ctl_cdr(ctl_cdr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // behavioural reference: synchronizer delay lines, phase and register image
    int         m_phase = 0;            // 0 idle, 1 read, 2 write, 3 gap
    logic       l_q[$], w_q[$], r_q[$];
    logic       l_prev = 1'b0;
    logic [3:0] m_mux = '0, m_addr = '0;
    logic [7:0] m_data = '0;
    logic [7:0] mreg [8];
    bit         model_on = 0;

    function automatic logic [63:0] model_flat();
        logic [63:0] f;
        for (int i = 0; i < 8; i++) f[i*8 +: 8] = mreg[i];
        return f;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_phase = 0; l_prev = 0; m_mux = 0; m_addr = 0; m_data = 0;
            for (int i = 0; i < 8; i++) mreg[i] = 8'h00;
            l_q = '{1'b0, 1'b0}; w_q = '{1'b1, 1'b1}; r_q = '{1'b1, 1'b1};
        end else begin
            logic lv, wv, rv, ra, wa;
            lv = l_q[0]; wv = w_q[0]; rv = r_q[0];
            ra = mode_ale ? !rv : (!wv && rv);
            wa = mode_ale ? !wv : (!wv && !rv);
            case (m_phase)
                0: if (wa || ra) begin
                       m_phase = wa ? 2 : 1;
                       m_addr  = mode_mux ? m_mux : addr_in;
                       m_data  = ad_in;
                   end
                1: if (!ra) m_phase = 0;
                2: if (wv) begin
                       if (m_addr < 8) mreg[m_addr[2:0]] = m_data;
                       m_phase = 3;
                   end
                default: m_phase = 0;
            endcase
            if (l_prev && !lv) m_mux = ad_in[3:0];
            l_prev = lv;
            void'(l_q.pop_front()); void'(w_q.pop_front()); void'(r_q.pop_front());
            l_q.push_back(addr_latch); w_q.push_back(wr_ds_n); r_q.push_back(rd_rw);
        end
        if (cyc > 100000) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected<100000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // per-clock comparison
    always @(negedge clk) begin
        if (model_on) begin
            chk("R7 ad_oe", 64'(ad_oe), 64'(m_phase == 1));
            if (m_phase == 1)
                chk("R3 ad_out", 64'(ad_out), 64'((m_addr < 8) ? mreg[m_addr[2:0]] : 8'h00));
            chk("R8 cfg_regs", cfg_regs, model_flat());
            chk("R10 ctl", {62'd0, ctl_dual, ctl_cdr}, {62'd0, mreg[5][4], mreg[5][0]});
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_addr(input logic [3:0] a);
        if (mode_mux) begin
            ad_in = {4'h0, a}; addr_latch = 1'b1; wait_n(3);
            addr_latch = 1'b0; wait_n(5);
        end else addr_in = a;
    endtask

    task automatic host_write(input logic [3:0] a, input logic [7:0] d, input bit late_change);
        set_addr(a);
        ad_in = d;
        if (!mode_ale) rd_rw = 1'b0;
        wr_ds_n = 1'b0; wait_n(5);
        if (late_change) begin ad_in = ~d; wait_n(3); end
        wr_ds_n = 1'b1; wait_n(2);
        rd_rw = 1'b1; wait_n(4);
    endtask

    task automatic host_read(input logic [3:0] a, input logic [7:0] exp, input string tag);
        set_addr(a);
        if (mode_ale) rd_rw = 1'b0; else begin rd_rw = 1'b1; wr_ds_n = 1'b0; end
        wait_n(5);
        chk(tag, {55'd0, ad_oe, ad_out}, {55'd0, 1'b1, exp});
        rd_rw = 1'b1; wr_ds_n = 1'b1; wait_n(5);
        chk({tag, " released (R7)"}, 64'(ad_oe), 64'd0);
    endtask

    initial begin
        wait_n(4);
        rst_n = 1'b1;
        model_on = 1;
        wait_n(1);
        // R1 reset state
        chk("R1 regs after reset", cfg_regs, 64'd0);
        chk("R1 oe after reset", 64'(ad_oe), 64'd0);
        chk("R1 ctl after reset", {62'd0, ctl_dual, ctl_cdr}, 64'd0);

        // R2 R3 R6: strobes, separate address pins
        mode_ale = 1'b1; mode_mux = 1'b0;
        host_write(4'd3, 8'hA5, 0);
        chk("R2 write reg3", 64'(cfg_regs[24 +: 8]), 64'hA5);
        host_read(4'd3, 8'hA5, "R3 R6 read reg3");

        // R7 timing: oe rises on the third edge after the read strobe falls
        addr_in = 4'd3; rd_rw = 1'b0;
        @(posedge clk); @(posedge clk); #1;
        chk("R7 oe not yet", 64'(ad_oe), 64'd0);
        @(posedge clk); #1;
        chk("R7 oe rises", 64'(ad_oe), 64'd1);
        rd_rw = 1'b1; wait_n(5);

        // R5 R10: shared bus, control register
        mode_mux = 1'b1;
        host_write(4'd5, 8'h11, 0);
        chk("R10 ctl_dual", 64'(ctl_dual), 64'd1);
        chk("R10 ctl_cdr", 64'(ctl_cdr), 64'd1);
        host_read(4'd5, 8'h11, "R5 shared-bus read reg5");

        // R4: data strobe with direction line
        mode_ale = 1'b0; mode_mux = 1'b0;
        host_write(4'd2, 8'h3C, 0);
        chk("R4 strobe write reg2", 64'(cfg_regs[16 +: 8]), 64'h3C);
        host_read(4'd2, 8'h3C, "R4 strobe read reg2");
        mode_mux = 1'b1;
        host_write(4'd5, 8'h10, 0);
        chk("R10 cdr cleared", {62'd0, ctl_dual, ctl_cdr}, 64'd2);
        host_read(4'd5, 8'h10, "R4 R5 strobe shared read");

        // R8: bus changes mid-cycle, first value stored once
        mode_ale = 1'b1; mode_mux = 1'b0;
        host_write(4'd7, 8'h5A, 1);
        chk("R8 entry value kept", 64'(cfg_regs[56 +: 8]), 64'h5A);

        // R9: unmapped address
        host_write(4'd12, 8'hFF, 0);
        chk("R9 write ignored", cfg_regs, model_flat());
        host_read(4'd12, 8'h00, "R9 unmapped read");

        wait_n(4);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule